// File: doc/BRIEF.md
# Layered OSD Pixel Compositor

This block builds one output pixel per dot clock from an external video backdrop pixel and four on-screen-display plane pixels (planes A, B, C and D). Each plane pixel comes with a region number, a flag that selects an 8-bit palette index or a 16-bit direct 5:6:5 colour, a 6-bit blend weight for that dot, a 2-bit attribute and an opacity bit. Palette indices are looked up in a 256-entry, 24-bit colour table that belongs to the pixel's region. The visible planes are then placed in priority order and alpha-blended over the backdrop, starting from the bottom layer.

The default stack puts plane D on top, then C, then B, then A, with the backdrop at the bottom. Each region has a priority level that can raise its planes above planes from regions with lower levels. The palette tables and the region priority levels are written through a single configuration write port. The result is a 24-bit colour and a 2-bit attribute. They appear a fixed three clocks after the inputs, and a valid flag is delayed to match.

Top module: `osd_compositor`

## Requirements
- R1: While reset is high, and on the first clock after it, `outVld` is 0, `outColor` is 0 and `outAttr` is 0.
- R2: A dot presented with `inVld` high on the clock edge that samples it produces its result in the third register stage. `outVld` equals `inVld` from three edges earlier, and no other output cycle is valid.
- R3: If no plane is visible, `outColor` equals the backdrop colour and `outAttr` equals the backdrop attribute of that dot.
- R4: In palette mode (`plnDirect[p]`=0), the plane colour is the table entry addressed by the plane's region number and the low byte of its 16-bit pixel field. Each region has a separate table.
- R5: In direct mode (`plnDirect[p]`=1), the 16-bit field is 5:6:5 red, green and blue (red in bits 15:11). Each channel widens to 8 bits by repeating its top bits below itself: red {r5,r5[4:2]}, green {g6,g6[5:4]}, blue {b5,b5[4:2]}.
- R6: A plane is skipped, so that lower layers show through, when its opacity bit is 0 or when it is in palette mode with index 0.
- R7: Each visible layer blends channel by channel as (a*fg + (63-a)*bg + 31)/63, truncated. Here a is the plane's 6-bit weight, fg is the plane colour and bg is the result below it. A weight of 63 gives fg and a weight of 0 gives bg.
- R8: When all regions have equal priority levels, layers stack with D above C above B above A above the backdrop, and blending runs from the bottom layer upward.
- R9: A plane's rank key is {priority level of its region, plane number}, with D=3 and A=0. A larger key stacks higher, so a region with a higher level lifts its planes above all planes with lower levels.
- R10: `outAttr` is the attribute of the topmost visible plane, or the backdrop attribute if no plane is visible.
- R11: Configuration address bit 10 selects the target: 0 for palette, 1 for priority table. Bits 9:8 give the region, and bits 7:0 give the palette index. A priority write takes its level from `cfgData[1:0]`, and all levels are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| inVld | input | 1 | Input dot valid |
| bgColor | input | 24 | Backdrop colour, R in bits 23:16 |
| bgAttr | input | 2 | Backdrop attribute |
| plnPix | input | 64 | Plane pixels, 16 bits each, plane A in bits 15:0 |
| plnDirect | input | 4 | 1 = direct 5:6:5, 0 = palette index |
| plnOpaque | input | 4 | Opacity bit per plane |
| plnAlpha | input | 24 | 6-bit blend weight per plane |
| plnRegion | input | 8 | 2-bit region number per plane |
| plnAttr | input | 8 | 2-bit attribute per plane |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 11 | Configuration address |
| cfgData | input | 24 | Configuration write data |
| outVld | output | 1 | Output pixel valid |
| outColor | output | 24 | Composited colour |
| outAttr | output | 2 | Attribute of the topmost visible layer |

## Verification
The bench uses the default build: four regions, giving a 1024-entry palette store and 2-bit priority levels. With this build every region can hold every distinct level, so every ranking of the four planes can be reached, including full reversal of the default order. Loading all 1024 palette entries with distinct values shows that a lookup that picks the wrong region or index produces a wrong colour.

// File: rtl/osdc_pkg.sv
package osdc_pkg;
  localparam int PLANES    = 4;
  localparam int PIX_W     = 16;
  localparam int IDX_W     = 8;
  localparam int ALPHA_W   = 6;
  localparam int CH_W      = 8;
  localparam int COL_W     = 3 * CH_W;
  localparam int ATTR_W    = 2;
  localparam int PRIO_W    = 2;
  localparam int SLOT_W    = $clog2(PLANES);
  localparam int ALPHA_MAX = (1 << ALPHA_W) - 1;

  typedef logic [COL_W-1:0] color_t;

  // strobes from ordering control to datapath; slot 0 is the topmost layer
  typedef struct packed {
    logic [PLANES-1:0]             slotLive;
    logic [PLANES-1:0][SLOT_W-1:0] slotSrc;
  } order_t;

  function automatic color_t expand565(logic [PIX_W-1:0] p);
    return {p[15:11], p[15:13], p[10:5], p[10:9], p[4:0], p[4:2]};
  endfunction

  function automatic color_t blendPx(color_t fg, color_t bg, logic [ALPHA_W-1:0] a);
    color_t r;
    int af;
    int ab;
    int s;
    af = int'(a);
    ab = ALPHA_MAX - af;
    for (int c = 0; c < 3; c++) begin
      s = af * int'(fg[c*CH_W +: CH_W]) + ab * int'(bg[c*CH_W +: CH_W]) + ALPHA_MAX / 2;
      r[c*CH_W +: CH_W] = CH_W'(s / ALPHA_MAX);
    end
    return r;
  endfunction
endpackage

// File: rtl/osdc_order.sv
module osdc_order
  import osdc_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  localparam int REG_W = $clog2(NUM_REGIONS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [PLANES*REG_W-1:0]  plnRegion,
  input  logic [PLANES*IDX_W-1:0]  plnIndex,
  input  logic [PLANES-1:0]        plnDirect,
  input  logic [PLANES-1:0]        plnOpaque,
  input  logic                     prioWe,
  input  logic [REG_W-1:0]         prioRegion,
  input  logic [PRIO_W-1:0]        prioLevel,
  output order_t                   order
);
  logic [PRIO_W-1:0]             prioTab [NUM_REGIONS];
  logic [PLANES-1:0][PRIO_W-1:0] prioQ;
  logic [PLANES-1:0]             liveQ;
  logic [PLANES-1:0][SLOT_W-1:0] rank;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_REGIONS; r++) prioTab[r] <= '0;
    end else if (prioWe) begin
      prioTab[prioRegion] <= prioLevel;
    end
  end

  // stage 1: region level lookup and visibility per plane
  always_ff @(posedge clk) begin
    if (rst) begin
      prioQ <= '0;
      liveQ <= '0;
    end else begin
      for (int p = 0; p < PLANES; p++) begin
        prioQ[p] <= prioTab[plnRegion[p*REG_W +: REG_W]];
        liveQ[p] <= plnOpaque[p] & (plnDirect[p] | (|plnIndex[p*IDX_W +: IDX_W]));
      end
    end
  end

  // rank = number of planes with a larger {level, plane} key
  always_comb begin
    for (int i = 0; i < PLANES; i++) begin
      int cnt;
      cnt = 0;
      for (int j = 0; j < PLANES; j++) begin
        if (j != i && {prioQ[j], SLOT_W'(j)} > {prioQ[i], SLOT_W'(i)}) cnt++;
      end
      rank[i] = SLOT_W'(cnt);
    end
  end

  always_comb begin
    order = '0;
    for (int i = 0; i < PLANES; i++) begin
      order.slotSrc[rank[i]]  = SLOT_W'(i);
      order.slotLive[rank[i]] = liveQ[i];
    end
  end
endmodule

// File: rtl/osdc_datapath.sv
module osdc_datapath
  import osdc_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  localparam int REG_W = $clog2(NUM_REGIONS),
  localparam int PAL_A = REG_W + IDX_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      inVld,
  input  logic [COL_W-1:0]          bgColor,
  input  logic [ATTR_W-1:0]         bgAttr,
  input  logic [PLANES*PIX_W-1:0]   plnPix,
  input  logic [PLANES-1:0]         plnDirect,
  input  logic [PLANES*ALPHA_W-1:0] plnAlpha,
  input  logic [PLANES*REG_W-1:0]   plnRegion,
  input  logic [PLANES*ATTR_W-1:0]  plnAttr,
  input  logic                      palWe,
  input  logic [PAL_A-1:0]          palAddr,
  input  logic [COL_W-1:0]          palData,
  input  order_t                    order,
  output logic                      outVld,
  output logic [COL_W-1:0]          outColor,
  output logic [ATTR_W-1:0]         outAttr
);
  color_t palMem [1 << PAL_A];

  // stage 1
  logic                             vld1;
  color_t                           bg1;
  logic [ATTR_W-1:0]                bgA1;
  logic [PLANES-1:0][COL_W-1:0]     pal1;
  logic [PLANES-1:0][COL_W-1:0]     dir1;
  logic [PLANES-1:0]                isDir1;
  logic [PLANES-1:0][ALPHA_W-1:0]   alpha1;
  logic [PLANES-1:0][ATTR_W-1:0]    attr1;
  // stage 2 (slot order, slot 0 on top)
  logic                             vld2;
  color_t                           bg2;
  logic [ATTR_W-1:0]                bgA2;
  logic [PLANES-1:0][COL_W-1:0]     col2;
  logic [PLANES-1:0][ALPHA_W-1:0]   alpha2;
  logic [PLANES-1:0][ATTR_W-1:0]    attr2;
  logic [PLANES-1:0]                live2;
  // stage 3 combinational
  color_t                           accColor;
  logic [ATTR_W-1:0]                accAttr;

  always_ff @(posedge clk) begin
    if (palWe) palMem[palAddr] <= palData;
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < PLANES; p++) begin
      pal1[p]   <= palMem[{plnRegion[p*REG_W +: REG_W], plnPix[p*PIX_W +: IDX_W]}];
      dir1[p]   <= expand565(plnPix[p*PIX_W +: PIX_W]);
      isDir1[p] <= plnDirect[p];
      alpha1[p] <= plnAlpha[p*ALPHA_W +: ALPHA_W];
      attr1[p]  <= plnAttr[p*ATTR_W +: ATTR_W];
    end
    bg1  <= bgColor;
    bgA1 <= bgAttr;
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < PLANES; s++) begin
      col2[s]   <= isDir1[order.slotSrc[s]] ? dir1[order.slotSrc[s]] : pal1[order.slotSrc[s]];
      alpha2[s] <= alpha1[order.slotSrc[s]];
      attr2[s]  <= attr1[order.slotSrc[s]];
    end
    bg2  <= bg1;
    bgA2 <= bgA1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld1  <= 1'b0;
      vld2  <= 1'b0;
      live2 <= '0;
    end else begin
      vld1  <= inVld;
      vld2  <= vld1;
      live2 <= order.slotLive;
    end
  end

  // bottom-up blend over the backdrop
  always_comb begin
    accColor = bg2;
    accAttr  = bgA2;
    for (int s = PLANES - 1; s >= 0; s--) begin
      if (live2[s]) begin
        accColor = blendPx(col2[s], accColor, alpha2[s]);
        accAttr  = attr2[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outVld   <= 1'b0;
      outColor <= '0;
      outAttr  <= '0;
    end else begin
      outVld   <= vld2;
      outColor <= accColor;
      outAttr  <= accAttr;
    end
  end
endmodule

// File: rtl/osd_compositor.sv
module osd_compositor
  import osdc_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  localparam int REG_W = $clog2(NUM_REGIONS),
  localparam int CFG_A = 1 + REG_W + IDX_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      inVld,
  input  logic [COL_W-1:0]          bgColor,
  input  logic [ATTR_W-1:0]         bgAttr,
  input  logic [PLANES*PIX_W-1:0]   plnPix,
  input  logic [PLANES-1:0]         plnDirect,
  input  logic [PLANES-1:0]         plnOpaque,
  input  logic [PLANES*ALPHA_W-1:0] plnAlpha,
  input  logic [PLANES*REG_W-1:0]   plnRegion,
  input  logic [PLANES*ATTR_W-1:0]  plnAttr,
  input  logic                      cfgWe,
  input  logic [CFG_A-1:0]          cfgAddr,
  input  logic [COL_W-1:0]          cfgData,
  output logic                      outVld,
  output logic [COL_W-1:0]          outColor,
  output logic [ATTR_W-1:0]         outAttr
);
  localparam int SEL_BIT = CFG_A - 1;

  logic                      palWe;
  logic                      prioWe;
  logic [PLANES*IDX_W-1:0]   plnIndex;
  order_t                    order;

  assign palWe  = cfgWe & ~cfgAddr[SEL_BIT];
  assign prioWe = cfgWe &  cfgAddr[SEL_BIT];

  for (genvar p = 0; p < PLANES; p++) begin : g_idx
    assign plnIndex[p*IDX_W +: IDX_W] = plnPix[p*PIX_W +: IDX_W];
  end

  osdc_order #(.NUM_REGIONS(NUM_REGIONS)) u_order (
    .clk        (clk),
    .rst        (rst),
    .plnRegion  (plnRegion),
    .plnIndex   (plnIndex),
    .plnDirect  (plnDirect),
    .plnOpaque  (plnOpaque),
    .prioWe     (prioWe),
    .prioRegion (cfgAddr[IDX_W +: REG_W]),
    .prioLevel  (cfgData[PRIO_W-1:0]),
    .order      (order)
  );

  osdc_datapath #(.NUM_REGIONS(NUM_REGIONS)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .inVld     (inVld),
    .bgColor   (bgColor),
    .bgAttr    (bgAttr),
    .plnPix    (plnPix),
    .plnDirect (plnDirect),
    .plnAlpha  (plnAlpha),
    .plnRegion (plnRegion),
    .plnAttr   (plnAttr),
    .palWe     (palWe),
    .palAddr   (cfgAddr[REG_W+IDX_W-1:0]),
    .palData   (cfgData),
    .order     (order),
    .outVld    (outVld),
    .outColor  (outColor),
    .outAttr   (outAttr)
  );
endmodule

// File: rtl/osdc_checks.sv
module osdc_checks
  import osdc_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                inVld,
  input logic [COL_W-1:0]    bgColor,
  input logic [ATTR_W-1:0]   bgAttr,
  input logic [PLANES-1:0]   plnOpaque,
  input logic [PIX_W-1:0]    topPix,
  input logic                topDirect,
  input logic [ALPHA_W-1:0]  topAlpha,
  input logic                outVld,
  input logic [COL_W-1:0]    outColor,
  input logic [ATTR_W-1:0]   outAttr
);
  logic [1:0]       sinceRst;
  logic [COL_W-1:0] topWide;

  always_ff @(posedge clk) begin
    if (rst) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  assign topWide = {topPix[15:11], topPix[15:13], topPix[10:5], topPix[10:9], topPix[4:0], topPix[4:2]};

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!outVld && outColor == '0 && outAttr == '0)); // R1

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 2'd3) |-> (outVld == $past(inVld, 3))); // R2

  AST_EMPTY_STACK_BG: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 2'd3 && $past(inVld, 3) && $past(plnOpaque, 3) == '0)
      |-> (outColor == $past(bgColor, 3) && outAttr == $past(bgAttr, 3))); // R3

  AST_TOP_DIRECT_PASS: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 2'd3 && $past(inVld, 3) && $past(plnOpaque, 3) == PLANES'(1 << (PLANES - 1))
      && $past(topDirect, 3) && $past(topAlpha, 3) == ALPHA_W'(ALPHA_MAX))
      |-> (outColor == $past(topWide, 3))); // R5
endmodule

bind osd_compositor osdc_checks u_checks (
  .clk       (clk),
  .rst       (rst),
  .inVld     (inVld),
  .bgColor   (bgColor),
  .bgAttr    (bgAttr),
  .plnOpaque (plnOpaque),
  .topPix    (plnPix[(osdc_pkg::PLANES-1)*osdc_pkg::PIX_W +: osdc_pkg::PIX_W]),
  .topDirect (plnDirect[osdc_pkg::PLANES-1]),
  .topAlpha  (plnAlpha[(osdc_pkg::PLANES-1)*osdc_pkg::ALPHA_W +: osdc_pkg::ALPHA_W]),
  .outVld    (outVld),
  .outColor  (outColor),
  .outAttr   (outAttr)
);

// File: tb/osd_compositor_tb.sv
module osd_compositor_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inVld = 1'b0;
  logic [23:0] bgColor = '0;
  logic [1:0]  bgAttr = '0;
  logic [63:0] plnPix = '0;
  logic [3:0]  plnDirect = '0;
  logic [3:0]  plnOpaque = '0;
  logic [23:0] plnAlpha = '0;
  logic [7:0]  plnRegion = '0;
  logic [7:0]  plnAttr = '0;
  logic        cfgWe = 1'b0;
  logic [10:0] cfgAddr = '0;
  logic [23:0] cfgData = '0;
  logic        outVld;
  logic [23:0] outColor;
  logic [1:0]  outAttr;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  logic [25:0] expQ [$];
  int          cycQ [$];
  string       tagQ [$];

  logic [23:0] palSh [4][256];
  int          prioSh [4];

  osd_compositor u_dut (
    .clk(clk), .rst(rst), .inVld(inVld), .bgColor(bgColor), .bgAttr(bgAttr),
    .plnPix(plnPix), .plnDirect(plnDirect), .plnOpaque(plnOpaque), .plnAlpha(plnAlpha),
    .plnRegion(plnRegion), .plnAttr(plnAttr), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .outVld(outVld), .outColor(outColor), .outAttr(outAttr)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [23:0] palVal(int r, int i);
    return {8'(i * 7 + r * 40), 8'(i ^ (r * 85)), 8'(255 - i + r)};
  endfunction

  function automatic int chBlend(int f, int b, int a);
    return (a * f + (63 - a) * b + 31) / 63;
  endfunction

  function automatic logic [23:0] widen(logic [15:0] p);
    int r5, g6, b5;
    r5 = int'(p[15:11]); g6 = int'(p[10:5]); b5 = int'(p[4:0]);
    return {8'(r5 * 8 + r5 / 4), 8'(g6 * 4 + g6 / 16), 8'(b5 * 8 + b5 / 4)};
  endfunction

  function automatic logic [25:0] model(logic [63:0] pix, logic [3:0] dir, logic [3:0] opq,
      logic [23:0] alp, logic [7:0] rg, logic [7:0] at, logic [23:0] bg, logic [1:0] bgA);
    logic [23:0] acc;
    logic [1:0]  att;
    acc = bg; att = bgA;
    for (int k = 0; k < 16; k++) begin
      for (int p = 0; p < 4; p++) begin
        if (prioSh[int'(rg[p*2 +: 2])] * 4 + p == k) begin
          logic [15:0] px;
          logic [23:0] fg;
          int a;
          px = pix[p*16 +: 16];
          if (opq[p] && (dir[p] || px[7:0] != 8'd0)) begin
            fg = dir[p] ? widen(px) : palSh[int'(rg[p*2 +: 2])][int'(px[7:0])];
            a = int'(alp[p*6 +: 6]);
            for (int c = 0; c < 3; c++)
              acc[c*8 +: 8] = 8'(chBlend(int'(fg[c*8 +: 8]), int'(acc[c*8 +: 8]), a));
            att = at[p*2 +: 2];
          end
        end
      end
    end
    return {att, acc};
  endfunction

  task automatic cfgWrite(logic [10:0] a, logic [23:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(posedge clk); #1;
    cfgWe = 1'b0;
  endtask

  task automatic setPrio(int r, int lvl);
    cfgWrite({1'b1, 2'(r), 8'h00}, 24'(lvl));
    prioSh[r] = lvl;
  endtask

  task automatic sendDot(logic [63:0] pix, logic [3:0] dir, logic [3:0] opq, logic [23:0] alp,
      logic [7:0] rg, logic [7:0] at, logic [23:0] bg, logic [1:0] bgA, string tag);
    inVld = 1'b1; plnPix = pix; plnDirect = dir; plnOpaque = opq; plnAlpha = alp;
    plnRegion = rg; plnAttr = at; bgColor = bg; bgAttr = bgA;
    expQ.push_back(model(pix, dir, opq, alp, rg, at, bg, bgA));
    cycQ.push_back(cyc + 3);
    tagQ.push_back(tag);
    @(posedge clk); #1;
    inVld = 1'b0;
  endtask

  task automatic idle(int n);
    inVld = 1'b0;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && outVld) begin
      tests++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R2 unexpected valid output: got color=%06h attr=%0d, expected no output", outColor, outAttr);
      end else begin
        logic [25:0] e;
        int ec;
        string t;
        e = expQ.pop_front(); ec = cycQ.pop_front(); t = tagQ.pop_front();
        if (ec != cyc) begin
          fails++;
          $display("FAIL R2 (%s) output cycle: got %0d, expected %0d", t, cyc, ec);
        end else if ({outAttr, outColor} !== e) begin
          fails++;
          $display("FAIL %s: got color=%06h attr=%0d, expected color=%06h attr=%0d",
                   t, outColor, outAttr, e[23:0], e[25:24]);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got hung run, expected completion");
    finishRun();
  end

  initial begin
    for (int r = 0; r < 4; r++) prioSh[r] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    tests++;
    if (outVld !== 1'b0 || outColor !== 24'h0 || outAttr !== 2'd0) begin
      fails++;
      $display("FAIL R1 reset state: got vld=%b color=%06h attr=%0d, expected 0 0 0", outVld, outColor, outAttr);
    end
    @(posedge clk); #1;
    rst = 1'b0;

    // R11: palette writes fill every region table
    for (int r = 0; r < 4; r++)
      for (int i = 0; i < 256; i++) begin
        palSh[r][i] = palVal(r, i);
        cfgWrite({1'b0, 2'(r), 8'(i)}, palSh[r][i]);
      end
    idle(2);

    // R3, R10: nothing visible
    sendDot(64'h0000_0000_0000_0012, 4'h0, 4'h0, 24'hFFFFFF, 8'h00, 8'hFF, 24'h123456, 2'd2, "R3");
    // R4: palette lookup region 2 index 45, then region 1 same index
    sendDot(64'h0000_0000_0000_0045, 4'h0, 4'h1, 24'h00003F, 8'h02, 8'h01, 24'h000000, 2'd0, "R4");
    sendDot(64'h0000_0000_0000_0045, 4'h0, 4'h1, 24'h00003F, 8'h01, 8'h01, 24'h000000, 2'd0, "R4");
    // R5: direct colour on plane B and plane D
    sendDot(64'h0000_0000_F81F_0000, 4'h2, 4'h2, 24'h000FC0, 8'h00, 8'h04, 24'h00FF00, 2'd0, "R5");
    sendDot(64'h1234_0000_0000_0000, 4'h8, 4'h8, 24'hFC0000, 8'h00, 8'hC0, 24'h00FF00, 2'd1, "R5");
    // R6: index 0 in palette mode and clear opacity bit are skipped
    sendDot(64'h0000_0000_0000_0000, 4'h0, 4'h4, 24'h03F000, 8'h30, 8'h30, 24'hABCDEF, 2'd1, "R6");
    sendDot(64'hFFFF_0000_0000_0000, 4'h8, 4'h0, 24'hFC0000, 8'h00, 8'hC0, 24'hABCDEF, 2'd3, "R6");
    // R7: mid weight and weight 0
    sendDot(64'h0000_0000_0000_FFFF, 4'h1, 4'h1, 24'h000020, 8'h00, 8'h02, 24'h000000, 2'd0, "R7");
    sendDot(64'h0000_0000_0000_FFFF, 4'h1, 4'h1, 24'h000000, 8'h00, 8'h02, 24'h204060, 2'd0, "R7");
    sendDot(64'h0000_0000_0000_07E0, 4'h1, 4'h1, 24'h000011, 8'h00, 8'h02, 24'hFF0080, 2'd0, "R7");
    // R8, R10: four layers default order
    sendDot(64'hF800_07E0_001F_FFFF, 4'hF, 4'hF, {6'd20, 6'd40, 6'd10, 6'd63}, 8'h00, 8'b11_10_01_00, 24'h101010, 2'd0, "R8");
    sendDot(64'h0011_0022_0033_0044, 4'h0, 4'hF, {6'd63, 6'd30, 6'd30, 6'd30}, 8'hE4, 8'b01_10_11_00, 24'h808080, 2'd2, "R10");
    idle(5);

    // R9, R11: region 1 lifted above region 0
    setPrio(1, 3);
    sendDot(64'hF800_0000_0000_001F, 4'h9, 4'h9, {6'd63, 6'd0, 6'd0, 6'd63}, 8'b00_00_00_01, 8'b10_00_00_01, 24'h000000, 2'd0, "R9");
    sendDot(64'hF800_0000_0000_001F, 4'h9, 4'h9, {6'd63, 6'd0, 6'd0, 6'd33}, 8'b00_00_00_01, 8'b10_00_00_01, 24'h00FF00, 2'd0, "R9");
    setPrio(0, 1); setPrio(2, 2); setPrio(3, 0);
    sendDot(64'h0101_0202_0303_0404, 4'h0, 4'hF, {6'd50, 6'd40, 6'd30, 6'd63}, 8'b00_10_01_00, 8'b11_10_01_00, 24'h204080, 2'd1, "R11");
    idle(5);

    // mixed random traffic with changing priority levels
    for (int round = 0; round < 6; round++) begin
      for (int r = 0; r < 4; r++) setPrio(r, int'($urandom_range(0, 3)));
      for (int n = 0; n < 50; n++) begin
        logic [63:0] px;
        logic [23:0] al;
        px = {$urandom(), $urandom()};
        if ($urandom_range(0, 3) == 0) px[7:0] = 8'h00;
        al = 24'($urandom());
        if ($urandom_range(0, 2) == 0) al[23:18] = 6'd63;
        if ($urandom_range(0, 2) == 0) al[5:0] = 6'd0;
        sendDot(px, 4'($urandom()), 4'($urandom()), al, 8'($urandom()), 8'($urandom()),
                24'($urandom()), 2'($urandom()), (round % 2 == 0) ? "R9" : "R8");
        if ($urandom_range(0, 7) == 0) idle(1);
      end
    end
    idle(6);

    tests++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R2 missing outputs: got %0d pending, expected 0", expQ.size());
    end
    finishRun();
  end
endmodule